// File: doc/BRIEF.md
# Flash Sector Write-Guard

This block decides whether a program or erase request that targets a serial NOR flash array must be blocked, because the target lies inside the region the status register marks as write-protected. The array holds 512 sectors of 64 KiB each, 32 MiB in total. A sector's index is the upper nine bits of the 25-bit byte address.

The command unit presents the current status byte, the byte address and an operation code with a request strobe. One clock later the block returns a verdict flag with its own valid strobe. The command unit uses the flag to drop the operation. The status byte carries a four-bit protection level split over non-adjacent bits. A level n of 1 or more covers 2^(n-1) sectors, and a separate anchor bit places that window at the high end or the low end of the array. A bulk erase is treated as touching every sector. A read never touches the array contents, so it is never blocked.

Top module: `flash_guard`

## Requirements
- R1: The protection level is {statusByte[6], statusByte[4], statusByte[3], statusByte[2]} (level bit 3 from status bit 6, level bits 2..0 from status bits 4..2). Status bits 0, 1 and 7 have no effect on the verdict.
- R2: Level 0 protects no sector. No program, sector erase or bulk erase is blocked.
- R3: Level n of 1 or more protects min(2^(n-1), 512) sectors, so levels 10 to 15 cover the whole array.
- R4: With statusByte[5] = 0 (high anchor), sectors from 512 minus the protected count up to 511 are protected.
- R5: With statusByte[5] = 1 (low anchor), sectors 0 up to the protected count minus 1 are protected.
- R6: The target sector is opAddr[24:16]. opAddr[15:0] has no effect on the verdict.
- R7: opKind 1 (page program) and opKind 2 (sector erase) are blocked exactly when the target sector is protected.
- R8: opKind 3 (bulk erase) is blocked exactly when the protected count is nonzero, whatever the address.
- R9: opKind 0 (read) is never blocked.
- R10: blockValid is high in the cycle after a cycle with reqValid high, and low otherwise. blockOut carries the verdict for that request and is 0 whenever blockValid is 0.
- R11: While rstN is low, blockValid and blockOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request strobe; the inputs below are sampled with it |
| opKind | input | 2 | 0 read, 1 page program, 2 sector erase, 3 bulk erase |
| opAddr | input | 25 | Byte address of the target |
| statusByte | input | 8 | Current status register value |
| blockValid | output | 1 | Verdict valid, one cycle after the request |
| blockOut | output | 1 | 1 when the operation must be suppressed |

## Verification
The hardest cases sit on the edges of the protected window, one sector inside and one sector outside. These edges move with both the level and the anchor. They also include the levels above 9, where the doubling count has to saturate at the array size rather than wrap. The stimulus table places addresses exactly on those sector boundaries for small, middle and saturated levels under both anchors. It also sets the unused status bits and the low address offsets to values that would flip the verdict if they leaked into the decision.

// File: rtl/flash_guard_pkg.sv
package flash_guard_pkg;
  localparam int SECTOR_BITS = 16;
  localparam int SECTOR_LOG2 = 9;
  localparam int ADDR_W = SECTOR_BITS + SECTOR_LOG2;
  localparam int LEVEL_W = 4;
  localparam int LVL_LO_POS = 2;
  localparam int LVL_HI_POS = 6;
  localparam int ANCHOR_POS = 5;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_PROG   = 2'd1,
    OP_SECERA = 2'd2,
    OP_BULK   = 2'd3
  } opKind_e;

  typedef struct packed {
    logic capture;
    logic useSector;
    logic useAny;
  } guardStrobe_t;
endpackage

// File: rtl/flash_guard_ctrl.sv
module flash_guard_ctrl
  import flash_guard_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  input  logic [1:0]   opKind,
  output guardStrobe_t strobe,
  output logic         validQ
);
  // R7, R8, R9: choose which verdict the datapath latches
  always_comb begin
    strobe = '0;
    strobe.capture = reqValid;
    if (reqValid) begin
      unique case (opKind_e'(opKind))
        OP_PROG, OP_SECERA: strobe.useSector = 1'b1;
        OP_BULK:            strobe.useAny = 1'b1;
        default:            ;
      endcase
    end
  end

  // R10, R11: verdict valid one cycle after the request
  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= reqValid;
  end
endmodule

// File: rtl/flash_guard_dp.sv
module flash_guard_dp
  import flash_guard_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  guardStrobe_t       strobe,
  input  logic [ADDR_W-1:0]  opAddr,
  input  logic [7:0]         statusByte,
  output logic               flagQ
);
  localparam int CNT_W = SECTOR_LOG2 + 1;
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(1) << SECTOR_LOG2;
  localparam logic [LEVEL_W-1:0] CAP_LVL = LEVEL_W'(SECTOR_LOG2 + 1);

  logic [LEVEL_W-1:0]     level;
  logic                   lowAnchor;
  logic [SECTOR_LOG2-1:0] sector;
  logic [CNT_W-1:0]       protCount;
  logic [CNT_W-1:0]       topStart;
  logic                   inWindow;
  logic                   anyProt;
  logic                   verdict;
  logic                   unusedBits;

  // R1: level bits gathered from split status positions
  assign level     = {statusByte[LVL_HI_POS], statusByte[LVL_LO_POS +: LEVEL_W-1]};
  assign lowAnchor = statusByte[ANCHOR_POS];
  // R6: sector index is the upper address field
  assign sector    = opAddr[ADDR_W-1:SECTOR_BITS];
  assign unusedBits = ^{statusByte[7], statusByte[1:0], opAddr[SECTOR_BITS-1:0]};

  // R2, R3: doubling count, saturated at the array size
  always_comb begin
    if (level == '0)           protCount = '0;
    else if (level >= CAP_LVL) protCount = FULL_CNT;
    else                       protCount = CNT_W'(1) << (level - LEVEL_W'(1));
  end

  assign anyProt  = (protCount != '0);
  assign topStart = FULL_CNT - protCount;

  // R4, R5: window anchored high or low
  always_comb begin
    if (lowAnchor) inWindow = ({1'b0, sector} < protCount);
    else           inWindow = anyProt && ({1'b0, sector} >= topStart);
  end

  assign verdict = (strobe.useSector & inWindow) | (strobe.useAny & anyProt);

  // R10, R11: registered verdict, cleared between requests
  always_ff @(posedge clk) begin
    if (!rstN)              flagQ <= 1'b0;
    else if (strobe.capture) flagQ <= verdict;
    else                    flagQ <= 1'b0;
  end
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import flash_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        opKind,
  input  logic [ADDR_W-1:0] opAddr,
  input  logic [7:0]        statusByte,
  output logic              blockValid,
  output logic              blockOut
);
  guardStrobe_t strobe;

  flash_guard_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .opKind   (opKind),
    .strobe   (strobe),
    .validQ   (blockValid)
  );

  flash_guard_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .opAddr     (opAddr),
    .statusByte (statusByte),
    .flagQ      (blockOut)
  );
endmodule

// File: rtl/flash_guard_checker.sv
module flash_guard_checker
  import flash_guard_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic [1:0]        opKind,
  input logic [ADDR_W-1:0] opAddr,
  input logic [7:0]        statusByte,
  input logic              blockValid,
  input logic              blockOut
);
  logic lvlZero;
  logic [SECTOR_LOG2-1:0] sec;
  assign lvlZero = ({statusByte[6], statusByte[4:2]} == 4'd0);
  assign sec = opAddr[ADDR_W-1:SECTOR_BITS];

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> blockValid);
  a_r10_valid_drops: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !blockValid);
  a_r10_flag_idle: assert property (@(posedge clk) disable iff (!rstN)
    !blockValid |-> !blockOut);
  a_r9_read_free: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opKind == 2'd0) |=> !blockOut);
  a_r2_level_zero: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && lvlZero) |=> !blockOut);
  a_r8_bulk_blocked: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opKind == 2'd3 && !lvlZero) |=> blockOut);
  a_r4_top_last: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opKind == 2'd1 && !lvlZero && !statusByte[5] && sec == '1) |=> blockOut);
  a_r5_bottom_first: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opKind == 2'd1 && !lvlZero && statusByte[5] && sec == '0) |=> blockOut);
endmodule

bind flash_guard flash_guard_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .opKind     (opKind),
  .opAddr     (opAddr),
  .statusByte (statusByte),
  .blockValid (blockValid),
  .blockOut   (blockOut)
);

// File: tb/flash_guard_test.sv
module flash_guard_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  opKind = 2'd0;
  logic [24:0] opAddr = '0;
  logic [7:0]  statusByte = 8'h00;
  logic        blockValid, blockOut;
  int          nChecks = 0;
  int          nFails = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  flash_guard uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opKind(opKind),
    .opAddr(opAddr), .statusByte(statusByte),
    .blockValid(blockValid), .blockOut(blockOut)
  );

  // entry: {req tag 4, status 8, addr 25, kind 2, expected 1}
  localparam int NV = 24;
  localparam logic [39:0] VEC [NV] = '{
    {4'd2,  8'h00, 25'h1FF0000, 2'd1, 1'b0},  // R2 level 0
    {4'd4,  8'h04, 25'h1FF0000, 2'd1, 1'b1},  // R4 level 1 top
    {4'd4,  8'h04, 25'h1FE0000, 2'd1, 1'b0},  // R4
    {4'd4,  8'h0C, 25'h1FC0000, 2'd1, 1'b1},  // R4 level 3 -> 508..511
    {4'd4,  8'h0C, 25'h1FB0000, 2'd1, 1'b0},  // R4
    {4'd1,  8'h40, 25'h1800000, 2'd1, 1'b1},  // R1 level 8 -> 384..511
    {4'd1,  8'h40, 25'h17F0000, 2'd1, 1'b0},  // R1
    {4'd3,  8'h48, 25'h0000000, 2'd1, 1'b1},  // R3 level 10 saturates
    {4'd3,  8'h7C, 25'h1FF0000, 2'd1, 1'b1},  // R3 level 15 bottom
    {4'd3,  8'h44, 25'h0000000, 2'd1, 1'b0},  // R3 level 9 top, 256..511
    {4'd5,  8'h24, 25'h0000000, 2'd1, 1'b1},  // R5 level 1 bottom
    {4'd5,  8'h24, 25'h0010000, 2'd1, 1'b0},  // R5
    {4'd5,  8'h64, 25'h0FF0000, 2'd1, 1'b1},  // R5 level 9 -> 0..255
    {4'd5,  8'h64, 25'h1000000, 2'd1, 1'b0},  // R5
    {4'd7,  8'h0C, 25'h1FD0000, 2'd2, 1'b1},  // R7 sector erase
    {4'd7,  8'h0C, 25'h0000000, 2'd2, 1'b0},  // R7
    {4'd8,  8'h04, 25'h0000000, 2'd3, 1'b1},  // R8 bulk, any protection
    {4'd8,  8'h20, 25'h1FF0000, 2'd3, 1'b0},  // R8 bulk, level 0
    {4'd9,  8'h5C, 25'h1FF0000, 2'd0, 1'b0},  // R9 read never blocked
    {4'd1,  8'h83, 25'h1FF0000, 2'd1, 1'b0},  // R1 stray bits ignored
    {4'd1,  8'h87, 25'h1FE0000, 2'd1, 1'b0},  // R1 stray bits, level 1
    {4'd6,  8'h04, 25'h1FFFFFF, 2'd1, 1'b1},  // R6 top offset
    {4'd6,  8'h04, 25'h1FEFFFF, 2'd1, 1'b0},  // R6 offset does not carry
    {4'd6,  8'h24, 25'h000FFFF, 2'd1, 1'b1}   // R6
  };

  task automatic check(input string tag, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R11 reset valid", blockValid, 1'b0);
    check("R11 reset flag", blockOut, 1'b0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      statusByte = VEC[i][35:28];
      opAddr     = VEC[i][27:3];
      opKind     = VEC[i][2:1];
      reqValid   = 1'b1;
      @(negedge clk);
      reqValid = 1'b0;
      check("R10 valid after request", blockValid, 1'b1);
      check($sformatf("R%0d vector %0d", VEC[i][39:36], i), blockOut, VEC[i][0]);
    end

    // R10: idle cycle yields no verdict
    @(negedge clk);
    check("R10 idle valid", blockValid, 1'b0);
    check("R10 idle flag", blockOut, 1'b0);

    // R10: back-to-back requests, each verdict in its own cycle
    @(negedge clk);
    statusByte = 8'h04; opAddr = 25'h1FF0000; opKind = 2'd1; reqValid = 1'b1;
    @(negedge clk);
    check("R10 b2b first", blockOut, 1'b1);
    opAddr = 25'h0000000;
    @(negedge clk);
    reqValid = 1'b0;
    check("R10 b2b second", blockOut, 1'b0);
    check("R10 b2b valid", blockValid, 1'b1);

    // R11: reset while a request is pending
    @(negedge clk);
    opAddr = 25'h1FF0000; reqValid = 1'b1; rstN = 1'b0;
    @(negedge clk);
    check("R11 reset over request valid", blockValid, 1'b0);
    check("R11 reset over request flag", blockOut, 1'b0);
    reqValid = 1'b0; rstN = 1'b1;
    @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule